// File: doc/BRIEF.md
# Retention-Binned Refresh Scheduler

This block decides, for every refresh slot, whether the DRAM row currently under the refresh pointer needs refreshing. A single 64 ms refresh for all rows wastes work, because only a few weak rows need it. Instead, rows whose weakest cell retains charge for a short time are recorded in a few retention bins. Each bin is a Bloom filter. The shorter the retention class, the more often its members are refreshed. Rows that appear in no bin are refreshed at a relaxed default period of 256 ms.

A row pointer walks the array one row per refresh tick. Each full walk is one epoch, nominally 64 ms. Epochs are counted modulo 4. Bin 0 members (64 ms class) are due in every epoch. Bin 1 members (128 ms class) are due in even epochs. Bin 2 members and unflagged rows (256 ms class) are due only in epoch 0. A due row raises a request toward the command scheduler, which holds until it is acknowledged. A row that is not due is skipped in the tick cycle itself.

Bins are filled and cleared through a programming port driven by the retention profiler.

Top module: `rbr_sched`

## Requirements
- R1: After synchronous reset, `ref_req_o` is 0, `ref_row_o` is 0, the epoch is 0 and every bin is empty.
- R2: A tick accepted while no request is pending evaluates the row on `ref_row_o`. If that row is not due, the pointer advances by one (wrapping from the last row to 0) after that edge, and no request is raised.
- R3: If the evaluated row is due, `ref_req_o` is 1 from the next cycle, with that row on `ref_row_o`. Both hold until a cycle with `ref_ack_i` high. After that cycle the request drops and the pointer advances by one.
- R4: A tick arriving while a request is pending is dropped: the pointer does not move and the request stays. An acknowledge with no pending request has no effect.
- R5: The epoch counter increments, modulo 4, each time the pointer wraps from the last row to row 0.
- R6: In epoch 0 every row is due.
- R7: A row that is a member of bin 0 (`prog_bin_i` = 0) is due in every epoch.
- R8: A row that is a member of bin 1 (`prog_bin_i` = 1) is due in epochs 0 and 2. When a row is in several bins, the shortest period wins.
- R9: A row that is a member of bin 2 (`prog_bin_i` = 2), or of no bin, is due only in epoch 0.
- R10: An insert maps the row address through two XOR-fold hashes into the selected bin's bit vector and sets both bits. Membership is the AND of both bits, so an inserted row is never missed. An insert takes effect for ticks at later edges only. It cannot change a decision already pending, only those of later rows.
- R11: `prog_clr_i` empties all bins in one cycle. It overrides an insert issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_ins_i | input | 1 | Insert `prog_row_i` into bin `prog_bin_i` |
| prog_clr_i | input | 1 | Empty all bins |
| prog_bin_i | input | $clog2(NUM_BINS) | Target bin of an insert |
| prog_row_i | input | ROW_W | Row address to insert |
| tick_i | input | 1 | Refresh slot strobe |
| ref_req_o | output | 1 | Refresh request for `ref_row_o` |
| ref_ack_i | input | 1 | Command scheduler accepted the request |
| ref_row_o | output | ROW_W | Current row pointer |

## Verification
The bench builds the block with ROW_W=4 and IDX_W=4 (16 rows, 16-bit filters), keeping the default three bins. At this size the folds reduce to the identity, so membership is exact, and the bench can predict every decision arithmetically. The full 16-row walk is short enough to sweep every row through all four epoch values several times, with empty filters, programmed filters and after a clear. This reaches the wrap into each epoch, the overlapping-bin priority, mid-request inserts and the dropped tick and acknowledge cases.

// File: rtl/rbr_pkg.sv
package rbr_pkg;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_WAIT = 1'b1
    } rbr_state_e;

    // XOR-fold of an address of aw bits into iw bits; skew rotates each
    // successive chunk by one more position to give an independent hash.
    function automatic logic [31:0] rbr_hash(input logic [31:0] addr,
                                             input int aw,
                                             input int iw,
                                             input bit skew);
        logic [31:0] r;
        r = '0;
        for (int i = 0; i < 32; i++) begin
            if (i < aw) begin
                int p;
                p = skew ? ((i + i / iw) % iw) : (i % iw);
                r[p] = r[p] ^ addr[i];
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/rbr_bloom_bin.sv
module rbr_bloom_bin
    import rbr_pkg::*;
#(
    parameter int ROW_W = 16,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             ins,
    input  logic [ROW_W-1:0] ins_row,
    input  logic [ROW_W-1:0] q_row,
    output logic             hit
);
    localparam int NBITS = 1 << IDX_W;

    logic [NBITS-1:0] bits_q;
    logic [IDX_W-1:0] ins_a, ins_b, q_a, q_b;

    always_comb begin
        ins_a = IDX_W'(rbr_hash(32'(ins_row), ROW_W, IDX_W, 1'b0));
        ins_b = IDX_W'(rbr_hash(32'(ins_row), ROW_W, IDX_W, 1'b1));
        q_a   = IDX_W'(rbr_hash(32'(q_row), ROW_W, IDX_W, 1'b0));
        q_b   = IDX_W'(rbr_hash(32'(q_row), ROW_W, IDX_W, 1'b1));
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            bits_q <= '0;
        end else if (ins) begin
            bits_q[ins_a] <= 1'b1;
            bits_q[ins_b] <= 1'b1;
        end
    end

    assign hit = bits_q[q_a] & bits_q[q_b];

endmodule

// File: rtl/rbr_row_walker.sv
module rbr_row_walker #(
    parameter int ROW_W = 16,
    parameter int EP_W  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [ROW_W-1:0] row,
    output logic [EP_W-1:0]  epoch
);
    always_ff @(posedge clk) begin
        if (rst) begin
            row   <= '0;
            epoch <= '0;
        end else if (adv) begin
            row <= row + ROW_W'(1);
            if (&row) begin
                epoch <= epoch + EP_W'(1);
            end
        end
    end
endmodule

// File: rtl/rbr_due_eval.sv
module rbr_due_eval #(
    parameter int NUM_BINS = 3,
    parameter int EP_W     = NUM_BINS - 1
) (
    input  logic [NUM_BINS-1:0] hits,
    input  logic [EP_W-1:0]     epoch,
    output logic                due
);
    logic [NUM_BINS-1:0] bin_due;

    // Bin k has a period of 2^k epochs: due when the low k epoch bits are 0.
    for (genvar k = 0; k < NUM_BINS; k++) begin : g_bin
        if (k == 0) begin : g_every
            assign bin_due[k] = hits[k];
        end else begin : g_sparse
            localparam logic [EP_W-1:0] MASK = EP_W'((1 << k) - 1);
            assign bin_due[k] = hits[k] && ((epoch & MASK) == '0);
        end
    end

    assign due = (|bin_due) || (epoch == '0);

endmodule

// File: rtl/rbr_sched.sv
module rbr_sched
    import rbr_pkg::*;
#(
    parameter int ROW_W    = 16,
    parameter int IDX_W    = 8,
    parameter int NUM_BINS = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        prog_ins_i,
    input  logic                        prog_clr_i,
    input  logic [$clog2(NUM_BINS)-1:0] prog_bin_i,
    input  logic [ROW_W-1:0]            prog_row_i,
    input  logic                        tick_i,
    output logic                        ref_req_o,
    input  logic                        ref_ack_i,
    output logic [ROW_W-1:0]            ref_row_o
);
    localparam int EP_W  = NUM_BINS - 1;
    localparam int BIN_W = $clog2(NUM_BINS);

    rbr_state_e          state_q;
    logic [NUM_BINS-1:0] hits;
    logic [EP_W-1:0]     epoch_q;
    logic [ROW_W-1:0]    row_q;
    logic                due, adv;

    for (genvar b = 0; b < NUM_BINS; b++) begin : g_filt
        logic sel;
        assign sel = prog_ins_i && (prog_bin_i == BIN_W'(b));
        rbr_bloom_bin #(.ROW_W(ROW_W), .IDX_W(IDX_W)) bin_i (
            .clk     (clk),
            .rst     (rst),
            .clr     (prog_clr_i),
            .ins     (sel),
            .ins_row (prog_row_i),
            .q_row   (row_q),
            .hit     (hits[b])
        );
    end

    rbr_due_eval #(.NUM_BINS(NUM_BINS), .EP_W(EP_W)) due_i (
        .hits  (hits),
        .epoch (epoch_q),
        .due   (due)
    );

    rbr_row_walker #(.ROW_W(ROW_W), .EP_W(EP_W)) walk_i (
        .clk   (clk),
        .rst   (rst),
        .adv   (adv),
        .row   (row_q),
        .epoch (epoch_q)
    );

    always_comb begin
        adv = 1'b0;
        if (state_q == S_IDLE) begin
            adv = tick_i && !due;
        end else begin
            adv = ref_ack_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
        end else begin
            case (state_q)
                S_IDLE: if (tick_i && due) state_q <= S_WAIT;
                S_WAIT: if (ref_ack_i)     state_q <= S_IDLE;
                default:                   state_q <= S_IDLE;
            endcase
        end
    end

    assign ref_req_o = (state_q == S_WAIT);
    assign ref_row_o = row_q;

endmodule

// File: rtl/rbr_sched_chk.sv
module rbr_sched_chk #(
    parameter int ROW_W = 16,
    parameter int EP_W  = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             ack,
    input logic             req,
    input logic [ROW_W-1:0] row,
    input logic [EP_W-1:0]  epoch
);
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!req && row == '0 && epoch == '0));

    a_r3_req_held: assert property (@(posedge clk) disable iff (rst)
        (req && !ack) |=> (req && $stable(row)));

    a_r3_ack_drops: assert property (@(posedge clk) disable iff (rst)
        (req && ack) |=> !req);

    a_r2_skip_advance: assert property (@(posedge clk) disable iff (rst)
        (!req && tick) |=> (req || row == ROW_W'($past(row) + ROW_W'(1))));

    a_r6_epoch0_due: assert property (@(posedge clk) disable iff (rst)
        (!req && tick && epoch == '0) |=> req);

    a_r5_epoch_wrap: assert property (@(posedge clk) disable iff (rst)
        (req && ack && (&row)) |=> (row == '0 && epoch == EP_W'($past(epoch) + EP_W'(1))));

    a_r4_idle_ack: assert property (@(posedge clk) disable iff (rst)
        (!req && !tick && ack) |=> (!req && $stable(row)));
endmodule

bind rbr_sched rbr_sched_chk #(.ROW_W(ROW_W), .EP_W(EP_W)) chk_i (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick_i),
    .ack   (ref_ack_i),
    .req   (ref_req_o),
    .row   (ref_row_o),
    .epoch (epoch_q)
);

// File: tb/rbr_sched_tb.sv
`timescale 1ns/100ps
module rbr_sched_tb_top;
    localparam int ROW_W = 4;
    localparam int IDX_W = 4;
    localparam int NUM_BINS = 3;
    localparam int NROWS = 1 << ROW_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic prog_ins = 1'b0, prog_clr = 1'b0;
    logic [1:0] prog_bin = '0;
    logic [ROW_W-1:0] prog_row = '0;
    logic tick = 1'b0, ack = 1'b0;
    logic req;
    logic [ROW_W-1:0] row_o;

    int total = 0;
    int bad = 0;

    bit m_b0 [NROWS];
    bit m_b1 [NROWS];
    int m_row = 0;
    int m_ep = 0;

    always #2.5 clk = ~clk;

    rbr_sched #(.ROW_W(ROW_W), .IDX_W(IDX_W), .NUM_BINS(NUM_BINS)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .prog_ins_i (prog_ins),
        .prog_clr_i (prog_clr),
        .prog_bin_i (prog_bin),
        .prog_row_i (prog_row),
        .tick_i     (tick),
        .ref_req_o  (req),
        .ref_ack_i  (ack),
        .ref_row_o  (row_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit exp_due(input int r, input int e);
        return (e == 0) || m_b0[r] || (m_b1[r] && (e % 2 == 0));
    endfunction

    task automatic model_adv();
        if (m_row == NROWS - 1) m_ep = (m_ep + 1) % 4;
        m_row = (m_row + 1) % NROWS;
    endtask

    task automatic insert(input int r, input int b);
        @(negedge clk);
        prog_ins = 1'b1; prog_bin = 2'(b); prog_row = ROW_W'(r);
        @(negedge clk);
        prog_ins = 1'b0;
        if (b == 0) m_b0[r] = 1'b1;
        if (b == 1) m_b1[r] = 1'b1;
    endtask

    // One refresh slot; optional extra tick / insert while the request waits.
    task automatic slot(input bit extra_tick, input bit ins_pend, input int ins_r, input int ins_b);
        bit d;
        d = exp_due(m_row, m_ep);
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        chk(req == d, $sformatf("R6/R7/R8/R9 req row=%0d ep=%0d", m_row, m_ep), req, d);
        if (d) begin
            chk(row_o == ROW_W'(m_row), "R3 row on request", row_o, m_row);
            if (extra_tick) begin
                @(negedge clk); tick = 1'b1;
                @(negedge clk); tick = 1'b0;
                chk(req == 1'b1, "R4 tick while pending keeps req", req, 1);
                chk(row_o == ROW_W'(m_row), "R4 tick while pending keeps row", row_o, m_row);
            end
            if (ins_pend) insert(ins_r, ins_b);
            @(negedge clk);
            chk(req == 1'b1, "R3 req held without ack", req, 1);
            ack = 1'b1;
            @(negedge clk); ack = 1'b0;
            chk(req == 1'b0, "R3 req drops after ack", req, 0);
        end
        model_adv();
        chk(row_o == ROW_W'(m_row), "R2/R5 pointer advance", row_o, m_row);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req == 1'b0, "R1 reset req", req, 0);
        chk(row_o == '0, "R1 reset row", row_o, 0);

        // Idle ack has no effect (R4)
        ack = 1'b1; @(negedge clk); ack = 1'b0; @(negedge clk);
        chk(req == 1'b0 && row_o == '0, "R4 idle ack ignored", row_o, 0);

        // Epoch 0 with empty bins: all due (R6); epoch 1: none due (R1 empty bins)
        for (int i = 0; i < 2 * NROWS; i++) slot(i == 2, 1'b0, 0, 0);

        // Program bins (R7, R8, R9, overlap priority R8)
        insert(3, 0); insert(3, 2);
        insert(5, 1); insert(9, 1); insert(9, 2);
        insert(7, 2); insert(12, 2);

        // Epochs 2,3,0,1
        for (int i = 0; i < 4 * NROWS; i++) slot(1'b0, 1'b0, 0, 0);

        // Epoch 2: at row 3 (pending), insert row 4 into bin 0 (R10)
        for (int i = 0; i < NROWS; i++) begin
            if (m_row == 3) slot(1'b0, 1'b1, 4, 0);
            else slot(1'b0, 1'b0, 0, 0);
        end
        // Epoch 3: row 4 now due every epoch (R10)
        for (int i = 0; i < NROWS; i++) slot(1'b0, 1'b0, 0, 0);

        // Clear with a simultaneous insert: clear wins (R11)
        @(negedge clk);
        prog_clr = 1'b1; prog_ins = 1'b1; prog_bin = 2'd0; prog_row = 4'd6;
        @(negedge clk);
        prog_clr = 1'b0; prog_ins = 1'b0;
        for (int r = 0; r < NROWS; r++) begin m_b0[r] = 1'b0; m_b1[r] = 1'b0; end
        // Epochs 0,1,2: only epoch 0 due (R11, R9)
        for (int i = 0; i < 3 * NROWS; i++) slot(1'b0, 1'b0, 0, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule